// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns external pins into interrupt requests for a processor core. It has a parameterised number of clocked channels, two by default. Each one samples its pin into the clock domain and watches for one of four conditions, chosen by a 2-bit mode: a low level, any change, a falling edge or a rising edge. There is also one extra channel that catches edges without the clock. Its pin drives a toggle flop directly, and the toggle is then brought into the clock domain. A single bit picks whether this channel reacts to a falling or a rising edge.

Edge events and change events set a sticky pending flag for their channel. Software clears a flag by writing a 1 to its clear bit, and an acknowledge input for that channel clears it too. A low-level channel has no flag memory: its pending state simply follows the synchronised pin. Each channel's request is raised only while the channel's mask bit and the global enable are both set. A plain write port loads the modes, the mask and the clear bits. Changing the polarity of the extra edge channel can raise a request by itself. Software should therefore mask that channel, change the polarity, clear the flag and only then unmask it.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all mode bits and mask bits are 0, every pending flag is clear and no request is raised. The clocked synchronisers reset to the pin-high state.
- R2: `irq_req[i]` is 1 only while `gie` is 1, mask bit `i` is 1 and channel `i` is pending. The gate is combinational on `gie` and on the registered mask.
- R3: Mode 11 (bits `[2i+1:2i]` of `cfg_sync_mode`) is rising-edge mode. A rising pin sets the flag, and `pend` shows it at the third rising clock edge after the pin changes. A falling pin has no effect.
- R4: Mode 10 is falling-edge mode. A falling pin sets the flag at the third clock edge, and a rising pin has no effect.
- R5: Mode 01 is any-change mode. Both rising and falling pin transitions set the flag.
- R6: Mode 00 is low-level mode. `pend[i]` is 1 from the second clock edge after the pin goes low. It drops at the second edge after the pin returns high, and nothing of the level is remembered after that.
- R7: A set flag stays set, even while the channel is masked. It clears at the next clock edge after a write with `clr_we=1` and `clr_wdata[i]=1`, or after `ack[i]=1`.
- R8: If a new event and a clear fall in the same cycle, the event wins and the flag stays set.
- R9: The edge-only channel (index NSYNC) reacts to a falling edge when `cfg_async_rise=0` and to a rising edge when `cfg_async_rise=1`. Its flag is set at the third clock edge after the pin edge, and the opposite edge has no effect.
- R10: A write that changes `cfg_async_rise` can set the edge-only channel's flag without any pin activity, whenever the selected polarity changes from inactive to active.
- R11: In an edge mode, a pin pulse two clock periods wide is caught and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous for the edge-only capture flop |
| sync_pin | input | NSYNC | Pins of the clocked channels |
| async_pin | input | 1 | Pin of the edge-only channel |
| gie | input | 1 | Global interrupt enable |
| cfg_we | input | 1 | Loads both mode fields |
| cfg_sync_mode | input | 2*NSYNC | 2-bit mode per clocked channel |
| cfg_async_rise | input | 1 | Edge-only channel polarity, 1 = rising |
| mask_we | input | 1 | Loads the mask |
| mask_wdata | input | NSYNC+1 | Per-channel enable mask |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | NSYNC+1 | Flags to clear, one bit per channel |
| ack | input | NSYNC+1 | Per-channel acknowledge, clears the flag |
| pend | output | NSYNC+1 | Pending state per channel |
| irq_req | output | NSYNC+1 | Gated interrupt requests |

## Verification
For an edge event, `pend` and `irq_req` are due at the third rising clock edge after the pin changes. That is two synchroniser stages and then the flag register. For a level request the delay is two edges in each direction. A change to the mask or to a clear is seen one edge after the write, and a change to `gie` is seen at once. The bench drives every input on the falling clock edge and counts rising edges from there. It checks both one edge before a result is due, where the result must still be absent, and on the falling edge right after the edge where it is due. The same-cycle clear in R8 is aligned so that its strobe is live exactly at the edge that registers the event.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ext_irq_flag.sv
`timescale 1ns/1ps
module ext_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    // a set in the same cycle as a clear keeps the flag
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
endmodule

// File: rtl/ext_irq_sync_chan.sv
`timescale 1ns/1ps
module ext_irq_sync_chan
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_e mode_i,
    output logic   evt_o,
    output logic   low_o
);
    localparam int S = SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] sync;
        logic         prev;
    } st_t;

    st_t st_d, st_q;
    logic cur, old;

    assign cur = st_q.sync[S-1];
    assign old = st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[S-2:0], pin_i};
        st_d.prev = st_q.sync[S-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    always_comb begin
        case (mode_i)
            SENSE_ANY:  evt_o = cur ^ old;
            SENSE_FALL: evt_o = old & ~cur;
            SENSE_RISE: evt_o = ~old & cur;
            default:    evt_o = 1'b0;
        endcase
    end

    assign low_o = ~cur;

    a_r3_rise_needs_low_before: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_RISE && evt_o) |-> !$past(cur));
    a_r5_change_detected: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_ANY && cur != $past(cur)) |-> evt_o);
endmodule

// File: rtl/ext_irq_async_chan.sv
`timescale 1ns/1ps
module ext_irq_async_chan
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_i,
    output logic evt_o
);
    localparam int S = SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] sync;
        logic         prev;
    } st_t;

    logic edge_src;
    logic tog_q;
    st_t  st_d, st_q;

    // polarity select in front of the capture flop; a change of rise_i
    // can itself create an active edge
    assign edge_src = rise_i ? pin_i : ~pin_i;

    always_ff @(posedge edge_src or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[S-2:0], tog_q};
        st_d.prev = st_q.sync[S-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.sync[S-1] ^ st_q.prev;

    a_r9_toggle_reaches_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync[S-1] != $past(st_q.sync[S-1])) |-> evt_o);
endmodule

// File: rtl/ext_irq_sense.sv
`timescale 1ns/1ps
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NSYNC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSYNC-1:0]   sync_pin,
    input  logic               async_pin,
    input  logic               gie,
    input  logic               cfg_we,
    input  logic [2*NSYNC-1:0] cfg_sync_mode,
    input  logic               cfg_async_rise,
    input  logic               mask_we,
    input  logic [NSYNC:0]     mask_wdata,
    input  logic               clr_we,
    input  logic [NSYNC:0]     clr_wdata,
    input  logic [NSYNC:0]     ack,
    output logic [NSYNC:0]     pend,
    output logic [NSYNC:0]     irq_req
);
    localparam int NCH = NSYNC + 1;

    typedef struct packed {
        logic [2*NSYNC-1:0] modes;
        logic               rise;
        logic [NCH-1:0]     mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.modes = cfg_sync_mode;
            cfg_d.rise  = cfg_async_rise;
        end
        if (mask_we) cfg_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [NCH-1:0] evt, flag, clr;

    assign clr = ({NCH{clr_we}} & clr_wdata) | ack;

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        sense_e mode;
        logic   low;
        assign mode = sense_e'(cfg_q.modes[2*i +: 2]);

        ext_irq_sync_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (sync_pin[i]),
            .mode_i (mode),
            .evt_o  (evt[i]),
            .low_o  (low)
        );

        assign pend[i] = (mode == SENSE_LOW) ? low : flag[i];
    end

    ext_irq_async_chan u_async (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (async_pin),
        .rise_i (cfg_q.rise),
        .evt_o  (evt[NSYNC])
    );
    assign pend[NSYNC] = flag[NSYNC];

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        ext_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt[i]),
            .clr_i  (clr[i]),
            .flag_o (flag[i])
        );

        a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> (gie && cfg_q.mask[i]));
    end

    assign irq_req = {NCH{gie}} & cfg_q.mask & pend;
endmodule

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
    localparam int NSYNC = 2;
    localparam int NCH = NSYNC + 1;
    localparam int AI = NSYNC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSYNC-1:0] sync_pin = '1;
    logic             async_pin = 1'b1;
    logic             gie = 1'b0;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_sync_mode = '0;
    logic             cfg_async_rise = 1'b0;
    logic             mask_we = 1'b0;
    logic [NCH-1:0]   mask_wdata = '0;
    logic             clr_we = 1'b0;
    logic [NCH-1:0]   clr_wdata = '0;
    logic [NCH-1:0]   ack = '0;
    logic [NCH-1:0]   pend, irq_req;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ext_irq_sense #(.NSYNC(NSYNC)) uut (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .async_pin(async_pin),
        .gie(gie), .cfg_we(cfg_we), .cfg_sync_mode(cfg_sync_mode),
        .cfg_async_rise(cfg_async_rise), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .ack(ack),
        .pend(pend), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    // wait n rising edges, then settle on the falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [3:0] modes, input logic rise);
        cfg_sync_mode = modes; cfg_async_rise = rise; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic set_mask(input logic [NCH-1:0] m);
        mask_wdata = m; mask_we = 1'b1;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic clear_all();
        clr_wdata = '1; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
    endtask

    task automatic t_reset();
        check("R1 pend", |pend, 1'b0);
        check("R1 irq", |irq_req, 1'b0);
        gie = 1'b1;
        tick(1);
        check("R1 mask zero", |irq_req, 1'b0);
    endtask

    task automatic t_rise();
        set_cfg(4'b0011, 1'b0);
        clear_all();
        sync_pin[0] = 1'b0;
        tick(4);
        check("R3 falling ignored", pend[0], 1'b0);
        sync_pin[0] = 1'b1;
        tick(2);
        check("R3 not yet", pend[0], 1'b0);
        tick(1);
        check("R3 pend", pend[0], 1'b1);
        check("R3 irq", irq_req[0], 1'b1);
        clear_all();
        check("R7 clear write", pend[0], 1'b0);
    endtask

    task automatic t_fall();
        set_cfg(4'b1000, 1'b0);
        clear_all();
        sync_pin[1] = 1'b0;
        tick(3);
        check("R4 pend", pend[1], 1'b1);
        clear_all();
        sync_pin[1] = 1'b1;
        tick(4);
        check("R4 rising ignored", pend[1], 1'b0);
    endtask

    task automatic t_any();
        set_cfg(4'b0001, 1'b0);
        clear_all();
        sync_pin[0] = 1'b0;
        tick(3);
        check("R5 fall", pend[0], 1'b1);
        clear_all();
        sync_pin[0] = 1'b1;
        tick(3);
        check("R5 rise", pend[0], 1'b1);
        clear_all();
    endtask

    task automatic t_level();
        set_cfg(4'b0000, 1'b0);
        clear_all();
        sync_pin[1] = 1'b0;
        tick(1);
        check("R6 not yet", irq_req[1], 1'b0);
        tick(1);
        check("R6 level req", irq_req[1], 1'b1);
        clear_all();
        check("R6 held while low", pend[1], 1'b1);
        sync_pin[1] = 1'b1;
        tick(1);
        check("R6 still low", pend[1], 1'b1);
        tick(1);
        check("R6 released", pend[1], 1'b0);
        tick(3);
        check("R6 no memory", irq_req[1], 1'b0);
    endtask

    task automatic t_gate();
        set_cfg(4'b0011, 1'b0);
        clear_all();
        sync_pin[0] = 1'b0;
        tick(3);
        gie = 1'b0;
        sync_pin[0] = 1'b1;
        tick(3);
        check("R2 pend gie off", pend[0], 1'b1);
        check("R2 irq gie off", irq_req[0], 1'b0);
        gie = 1'b1;
        #0.5;
        check("R2 irq gie on", irq_req[0], 1'b1);
        set_mask('0);
        check("R7 masked no irq", irq_req[0], 1'b0);
        tick(3);
        check("R7 flag kept masked", pend[0], 1'b1);
        ack[0] = 1'b1;
        tick(1);
        ack[0] = 1'b0;
        check("R7 ack clears", pend[0], 1'b0);
        set_mask('1);
    endtask

    task automatic t_same_cycle();
        set_cfg(4'b0001, 1'b0);
        clear_all();
        sync_pin[0] = 1'b0;
        tick(3);
        check("R8 first event", pend[0], 1'b1);
        sync_pin[0] = 1'b1;
        tick(2);
        clr_wdata = '1; clr_we = 1'b1;
        tick(1);
        clr_we = 1'b0; clr_wdata = '0;
        check("R8 event wins", pend[0], 1'b1);
        clear_all();
    endtask

    task automatic t_pulse();
        set_cfg(4'b0011, 1'b0);
        sync_pin[0] = 1'b0;
        tick(4);
        clear_all();
        sync_pin[0] = 1'b1;
        tick(2);
        sync_pin[0] = 1'b0;
        tick(3);
        check("R11 short pulse", pend[0], 1'b1);
        clear_all();
        sync_pin[0] = 1'b1;
        tick(4);
        clear_all();
    endtask

    task automatic t_async();
        clear_all();
        async_pin = 1'b0;
        tick(2);
        check("R9 not yet", pend[AI], 1'b0);
        tick(1);
        check("R9 falling", pend[AI], 1'b1);
        clear_all();
        async_pin = 1'b1;
        tick(4);
        check("R9 rising ignored in fall mode", pend[AI], 1'b0);
        set_mask(3'b011);
        set_cfg(4'b0000, 1'b1);
        tick(4);
        check("R10 mode change event", pend[AI], 1'b1);
        clear_all();
        set_mask('1);
        async_pin = 1'b0;
        tick(4);
        check("R9 falling ignored in rise mode", pend[AI], 1'b0);
        async_pin = 1'b1;
        tick(3);
        check("R9 rising", pend[AI], 1'b1);
        check("R9 irq", irq_req[AI], 1'b1);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        set_mask('1);
        t_rise();
        t_fall();
        t_any();
        t_level();
        t_gate();
        t_same_cycle();
        t_pulse();
        t_async();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule